// File: doc/BRIEF.md
# Set-Associative Data TLB Lookup

This block translates 32-bit data virtual addresses into physical addresses through a small set-associative array of page entries. Each way keeps, per set, a match entry (virtual page number, valid flag, small usage counter) and a translate entry (physical page number, accessed and dirty flags, and read/write enables for user and supervisor mode). Pages are 8 KB. The low bits of the virtual page number select the set. A way hits when its stored full page number equals the lookup's page number and its valid flag is set. A hit returns the physical page number joined to the untranslated offset. A miss raises an exception request that carries the faulting address. Hardware refill is not done.

Software loads entries through a write port that selects a way, a set and one of the two entry kinds. Every hit updates the set's usage counters. The hit way reloads to the top count, and every other nonzero counter steps down by one. On a miss, the block names a victim way: the one with the smallest counter. The miss handler uses it to choose the entry to refill. When the translation enable input is low, addresses pass through unchanged and no counter moves.

Top module: `dtlb_xlate`

## Requirements
- R1: Synchronous reset clears every valid flag and every usage counter, and drives all registered outputs to zero. A lookup after reset therefore misses.
- R2: The set index is the virtual page number (address bits 31:13) modulo the set count. A way hits only if its valid flag is 1 and its stored 19-bit page number equals the whole lookup page number.
- R3: On a hit, `rsp_paddr` is the stored physical page number in bits 31:13 with address bits 12:0 copied from the virtual address. It is registered and valid the cycle after the request.
- R4: On a miss with translation enabled, `miss_req` is 1, `rsp_hit` is 0, `rsp_paddr` is 0 and `fault_vaddr` holds the virtual address.
- R5: On a hit, the access is checked against the translate entry's permission bits: bit 2 user read, bit 3 user write, bit 4 supervisor read, bit 5 supervisor write. Bit 0 (accessed) and bit 1 (dirty) are stored only. A cleared permission gives `fault_req`=1 with `rsp_hit`=1 and `fault_vaddr` set to the address.
- R6: On a hit, the hit way's counter is set to USTATES-1, and every other way in that set with a nonzero counter decrements by one.
- R7: On a miss, `miss_victim` gives the lowest-numbered way among those holding the smallest counter in the addressed set. A miss changes no counter.
- R8: When several ways of a set match, the highest-numbered way supplies the translation.
- R9: With `xlate_en` low, a request returns `rsp_paddr` equal to the virtual address with hit, miss and fault all 0, and leaves every counter unchanged.
- R10: A software write uses data bit 0 as valid, bits 2 and up as the counter and bits 31:13 as the page number (match entry), or bits 5:0 as the flags and bits 31:13 as the physical page number (translate entry). In the same cycle, a match entry write takes precedence over that entry's counter update.
- R11: A cycle without `req_valid` yields `rsp_valid`, `rsp_hit`, `miss_req` and `fault_req` all 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlate_en | input | 1 | Translation enable; low means pass-through |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a store (1) or a load (0) |
| req_super | input | 1 | Access is made in supervisor mode |
| sw_wr_en | input | 1 | Software entry write strobe |
| sw_way | input | WAY_W | Way to write |
| sw_set | input | SET_W | Set to write |
| sw_sel_xlate | input | 1 | 0 writes the match entry, 1 the translate entry |
| sw_wdata | input | 32 | Entry data |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address |
| miss_req | output | 1 | Miss exception request |
| fault_req | output | 1 | Page-fault exception request |
| fault_vaddr | output | 32 | Address that caused the miss or fault |
| miss_victim | output | WAY_W | Suggested way to refill on a miss |

## Verification
Every result (hit, physical address, miss, fault, faulting address and victim) becomes visible one clock after the edge that samples the request. The counter update from a hit takes effect at that same edge, so it shows up in the victim reported by the next lookup. The bench changes inputs on falling edges and reads outputs at the next falling edge, which is half a cycle after the one register stage. Counter behaviour is checked only through the victim reported by a miss lookup made after the stimulus.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // Translate-entry flags, LSB first: accessed, dirty, user rd, user wr, sup rd, sup wr
  typedef struct packed {
    logic swe;
    logic sre;
    logic uwe;
    logic ure;
    logic dirty;
    logic accessed;
  } dtlb_perm_t;

  localparam int PERM_W = 6;

endpackage

// File: rtl/dtlb_way_bank.sv
module dtlb_way_bank
  import dtlb_pkg::*;
#(
  parameter int SETS    = 16,
  parameter int VPN_W   = 19,
  parameter int CNT_W   = 1,
  parameter int CNT_MAX = 1,
  localparam int SET_W  = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  // lookup read side
  input  logic [SET_W-1:0] lk_set,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_match,
  output logic [VPN_W-1:0] lk_ppn,
  output dtlb_perm_t       lk_perm,
  output logic [CNT_W-1:0] lk_cnt,
  // usage counter update for set lk_set
  input  logic             upd_en,
  input  logic             upd_hit,
  // software write side
  input  logic             wr_match,
  input  logic             wr_xlate,
  input  logic [SET_W-1:0] wr_set,
  input  logic [VPN_W-1:0] wr_page,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_cnt,
  input  dtlb_perm_t       wr_perm
);

  logic [VPN_W-1:0] vpn_mem  [SETS];
  logic [VPN_W-1:0] ppn_mem  [SETS];
  dtlb_perm_t       perm_mem [SETS];
  logic [SETS-1:0]  valid_q;
  logic [CNT_W-1:0] cnt_q    [SETS];

  logic sw_owns_set;
  assign sw_owns_set = wr_match && (wr_set == lk_set);

  // payload arrays: no reset, plain write port
  always_ff @(posedge clk) begin
    if (wr_match) vpn_mem[wr_set] <= wr_page;
    if (wr_xlate) begin
      ppn_mem[wr_set]  <= wr_page;
      perm_mem[wr_set] <= wr_perm;
    end
  end

  // valid flags and usage counters
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
    end else begin
      if (wr_match) begin
        valid_q[wr_set] <= wr_valid;
        cnt_q[wr_set]   <= wr_cnt;
      end
      if (upd_en && !sw_owns_set) begin
        if (upd_hit)
          cnt_q[lk_set] <= CNT_W'(CNT_MAX);
        else if (cnt_q[lk_set] != '0)
          cnt_q[lk_set] <= cnt_q[lk_set] - 1'b1;
      end
    end
  end

  assign lk_match = valid_q[lk_set] && (vpn_mem[lk_set] == lk_vpn);
  assign lk_ppn   = ppn_mem[lk_set];
  assign lk_perm  = perm_mem[lk_set];
  assign lk_cnt   = cnt_q[lk_set];

  assert_hit_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_hit && !sw_owns_set) |=> (cnt_q[$past(lk_set)] == CNT_W'(CNT_MAX)));

  assert_other_decay_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_hit && !sw_owns_set && (cnt_q[lk_set] != '0))
      |=> (cnt_q[$past(lk_set)] == $past(cnt_q[lk_set]) - 1'b1));

  assert_sw_priority_R10: assert property (@(posedge clk) disable iff (rst)
    wr_match |=> (cnt_q[$past(wr_set)] == $past(wr_cnt)) &&
                 (valid_q[$past(wr_set)] == $past(wr_valid)));

endmodule

// File: rtl/dtlb_way_pick.sv
module dtlb_way_pick #(
  parameter int WAYS  = 2,
  parameter int CNT_W = 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            match,
  input  logic [WAYS-1:0][CNT_W-1:0] cnt,
  output logic                       any_hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way
);

  // highest-numbered matching way wins
  always_comb begin
    any_hit = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) begin
        any_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // smallest counter, ties to the lowest way
  always_comb begin
    victim_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (cnt[w] < cnt[victim_way]) victim_way = WAY_W'(w);
    end
  end

  always_comb begin
    if (any_hit) begin
      assert_pick_highest_R8: assert (match[hit_way]);
    end
  end

endmodule

// File: rtl/dtlb_perm_check.sv
module dtlb_perm_check
  import dtlb_pkg::*;
(
  input  dtlb_perm_t perm,
  input  logic       is_write,
  input  logic       is_super,
  output logic       allowed
);

  logic unused_flags;
  assign unused_flags = perm.accessed ^ perm.dirty;

  always_comb begin
    unique case ({is_super, is_write})
      2'b00:   allowed = perm.ure;
      2'b01:   allowed = perm.uwe;
      2'b10:   allowed = perm.sre;
      default: allowed = perm.swe;
    endcase
  end

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_OFF_W = 13,
  parameter int SETS       = 16,
  parameter int WAYS       = 2,
  parameter int USTATES    = 2,
  localparam int VPN_W   = ADDR_W - PAGE_OFF_W,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W   = $clog2(USTATES),
  localparam int CNT_MAX = USTATES - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlate_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_super,
  input  logic              sw_wr_en,
  input  logic [WAY_W-1:0]  sw_way,
  input  logic [SET_W-1:0]  sw_set,
  input  logic              sw_sel_xlate,
  input  logic [ADDR_W-1:0] sw_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              miss_req,
  output logic              fault_req,
  output logic [ADDR_W-1:0] fault_vaddr,
  output logic [WAY_W-1:0]  miss_victim
);

  logic [VPN_W-1:0] lk_vpn;
  logic [SET_W-1:0] lk_set;
  logic             lookup_on;

  assign lk_vpn    = req_vaddr[ADDR_W-1:PAGE_OFF_W];
  assign lk_set    = lk_vpn[SET_W-1:0];
  assign lookup_on = req_valid && xlate_en;

  // software write field split
  logic [VPN_W-1:0] wr_page;
  logic             wr_valid;
  logic [CNT_W-1:0] wr_cnt;
  dtlb_perm_t       wr_perm;
  logic             unused_wdata;

  assign wr_page      = sw_wdata[ADDR_W-1:PAGE_OFF_W];
  assign wr_valid     = sw_wdata[0];
  assign wr_cnt       = sw_wdata[2 +: CNT_W];
  assign wr_perm      = dtlb_perm_t'(sw_wdata[PERM_W-1:0]);
  assign unused_wdata = ^sw_wdata[PAGE_OFF_W-1:PERM_W];

  logic [WAYS-1:0]            bank_match;
  logic [VPN_W-1:0]           bank_ppn  [WAYS];
  dtlb_perm_t                 bank_perm [WAYS];
  logic [WAYS-1:0][CNT_W-1:0] bank_cnt;

  logic             any_hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim_way;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic sel_way;
    assign sel_way = sw_wr_en && (sw_way == WAY_W'(w));

    dtlb_way_bank #(
      .SETS    (SETS),
      .VPN_W   (VPN_W),
      .CNT_W   (CNT_W),
      .CNT_MAX (CNT_MAX)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .lk_set   (lk_set),
      .lk_vpn   (lk_vpn),
      .lk_match (bank_match[w]),
      .lk_ppn   (bank_ppn[w]),
      .lk_perm  (bank_perm[w]),
      .lk_cnt   (bank_cnt[w]),
      .upd_en   (lookup_on && any_hit),
      .upd_hit  (hit_way == WAY_W'(w)),
      .wr_match (sel_way && !sw_sel_xlate),
      .wr_xlate (sel_way && sw_sel_xlate),
      .wr_set   (sw_set),
      .wr_page  (wr_page),
      .wr_valid (wr_valid),
      .wr_cnt   (wr_cnt),
      .wr_perm  (wr_perm)
    );
  end

  dtlb_way_pick #(
    .WAYS  (WAYS),
    .CNT_W (CNT_W)
  ) u_pick (
    .match      (bank_match),
    .cnt        (bank_cnt),
    .any_hit    (any_hit),
    .hit_way    (hit_way),
    .victim_way (victim_way)
  );

  logic access_ok;

  dtlb_perm_check u_perm (
    .perm     (bank_perm[hit_way]),
    .is_write (req_write),
    .is_super (req_super),
    .allowed  (access_ok)
  );

  logic [ADDR_W-1:0] hit_paddr;
  assign hit_paddr = {bank_ppn[hit_way], req_vaddr[PAGE_OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_paddr   <= '0;
      miss_req    <= 1'b0;
      fault_req   <= 1'b0;
      fault_vaddr <= '0;
      miss_victim <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= lookup_on && any_hit;
      miss_req    <= lookup_on && !any_hit;
      fault_req   <= lookup_on && any_hit && !access_ok;
      fault_vaddr <= (lookup_on && !(any_hit && access_ok)) ? req_vaddr : '0;
      miss_victim <= (lookup_on && !any_hit) ? victim_way : '0;
      if (!req_valid)     rsp_paddr <= '0;
      else if (!xlate_en) rsp_paddr <= req_vaddr;
      else if (any_hit)   rsp_paddr <= hit_paddr;
      else                rsp_paddr <= '0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit && !miss_req && !fault_req));

  assert_miss_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    miss_req |-> (rsp_valid && !rsp_hit && !fault_req));

  assert_fault_needs_hit_R5: assert property (@(posedge clk) disable iff (rst)
    fault_req |-> (rsp_hit && rsp_valid));

  assert_bypass_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlate_en) |=>
      (rsp_paddr == $past(req_vaddr)) && !rsp_hit && !miss_req && !fault_req);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_hit && !miss_req && !fault_req));

endmodule

// File: tb/dtlb_xlate_bench.sv
module dtlb_xlate_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        xlate_en, req_valid, req_write, req_super;
  logic [31:0] req_vaddr;
  logic        sw_wr_en, sw_sel_xlate;
  logic [0:0]  sw_way;
  logic [3:0]  sw_set;
  logic [31:0] sw_wdata;
  logic        rsp_valid, rsp_hit, miss_req, fault_req;
  logic [31:0] rsp_paddr, fault_vaddr;
  logic [0:0]  miss_victim;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dtlb_xlate u_dtlb_xlate (
    .clk(clk), .rst(rst), .xlate_en(xlate_en), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_super(req_super),
    .sw_wr_en(sw_wr_en), .sw_way(sw_way), .sw_set(sw_set),
    .sw_sel_xlate(sw_sel_xlate), .sw_wdata(sw_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .miss_req(miss_req), .fault_req(fault_req), .fault_vaddr(fault_vaddr),
    .miss_victim(miss_victim)
  );

  localparam logic [5:0] ALL_RW = 6'b111100;

  function automatic logic [31:0] mk_match(logic [18:0] vpn, logic v, logic cnt);
    return {vpn, 10'b0, cnt, 1'b0, v};
  endfunction

  function automatic logic [31:0] mk_xlate(logic [18:0] ppn, logic [5:0] fl);
    return {ppn, 7'b0, fl};
  endfunction

  function automatic logic [31:0] va(logic [18:0] vpn, logic [12:0] off);
    return {vpn, off};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sw_put(input logic way, input logic [3:0] set,
                        input logic sel, input logic [31:0] data);
    @(negedge clk);
    sw_wr_en = 1'b1; sw_way = way; sw_set = set; sw_sel_xlate = sel; sw_wdata = data;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  // drive at a falling edge; registered result read at the next falling edge
  task automatic look(input logic [31:0] a, input logic wr, input logic sup);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a; req_write = wr; req_super = sup;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe_victim(input logic [18:0] vpn, input logic exp, input string req);
    look(va(vpn, 13'h0), 1'b0, 1'b0);
    chk(req, "probe miss", 32'(miss_req), 32'd1);
    chk(req, "victim", 32'(miss_victim), 32'(exp));
  endtask

  task automatic t_reset_state;
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "paddr after reset", rsp_paddr, 32'd0);
    look(va(19'h00013, 13'h0AB), 1'b0, 1'b0);
    chk("R1", "miss after reset", 32'(miss_req), 32'd1);
    chk("R4", "hit on miss", 32'(rsp_hit), 32'd0);
    chk("R4", "fault address", fault_vaddr, va(19'h00013, 13'h0AB));
    chk("R4", "paddr on miss", rsp_paddr, 32'd0);
    chk("R7", "victim with cleared counters", 32'(miss_victim), 32'd0);
  endtask

  task automatic t_basic_hit;
    sw_put(1'b0, 4'd3, 1'b0, mk_match(19'h12343, 1'b1, 1'b0));
    sw_put(1'b0, 4'd3, 1'b1, mk_xlate(19'h0ABCD, ALL_RW));
    look(va(19'h12343, 13'h1F5), 1'b0, 1'b0);
    chk("R2", "hit", 32'(rsp_hit), 32'd1);
    chk("R3", "paddr", rsp_paddr, {19'h0ABCD, 13'h1F5});
    chk("R3", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R5", "no fault", 32'(fault_req), 32'd0);
  endtask

  task automatic t_usage_victim;
    // set 3 counters now: way0=1 way1=0
    probe_victim(19'h55553, 1'b1, "R7");
    sw_put(1'b1, 4'd3, 1'b0, mk_match(19'h77773, 1'b1, 1'b0));
    sw_put(1'b1, 4'd3, 1'b1, mk_xlate(19'h01111, ALL_RW));
    look(va(19'h77773, 13'h0042), 1'b1, 1'b1);
    chk("R3", "way1 paddr", rsp_paddr, {19'h01111, 13'h0042});
    probe_victim(19'h55553, 1'b0, "R6");
    look(va(19'h12343, 13'h0), 1'b0, 1'b0);
    chk("R6", "rehit way0", 32'(rsp_hit), 32'd1);
    probe_victim(19'h55553, 1'b1, "R6");
  endtask

  task automatic t_sw_priority;
    // way0=1 way1=0; hit way0 while rewriting its match entry with counter 0
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va(19'h12343, 13'h7); req_write = 1'b0; req_super = 1'b1;
    sw_wr_en = 1'b1; sw_way = 1'b0; sw_set = 4'd3; sw_sel_xlate = 1'b0;
    sw_wdata = mk_match(19'h12343, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b0; sw_wr_en = 1'b0;
    chk("R10", "hit during write", 32'(rsp_hit), 32'd1);
    probe_victim(19'h55553, 1'b0, "R10");
  endtask

  task automatic t_bypass;
    xlate_en = 1'b0;
    look(va(19'h12343, 13'h0999), 1'b1, 1'b0);
    chk("R9", "pass-through paddr", rsp_paddr, va(19'h12343, 13'h0999));
    chk("R9", "no hit", 32'(rsp_hit), 32'd0);
    chk("R9", "no miss", 32'(miss_req), 32'd0);
    chk("R9", "valid", 32'(rsp_valid), 32'd1);
    xlate_en = 1'b1;
    probe_victim(19'h55553, 1'b0, "R9");
  endtask

  task automatic t_vpn_compare;
    look(va(19'h02343, 13'h0), 1'b0, 1'b0);
    chk("R2", "upper page bits differ", 32'(miss_req), 32'd1);
    sw_put(1'b0, 4'd6, 1'b0, mk_match(19'h00A06, 1'b1, 1'b0));
    sw_put(1'b0, 4'd6, 1'b1, mk_xlate(19'h00200, ALL_RW));
    look(va(19'h00A06, 13'h1234), 1'b0, 1'b0);
    chk("R2", "set 6 hit paddr", rsp_paddr, {19'h00200, 13'h1234});
    look(va(19'h00A07, 13'h0), 1'b0, 1'b0);
    chk("R2", "neighbour set misses", 32'(miss_req), 32'd1);
    sw_put(1'b1, 4'd7, 1'b0, mk_match(19'h00017, 1'b0, 1'b0));
    sw_put(1'b1, 4'd7, 1'b1, mk_xlate(19'h00333, ALL_RW));
    look(va(19'h00017, 13'h0), 1'b0, 1'b0);
    chk("R2", "invalid entry misses", 32'(miss_req), 32'd1);
  endtask

  task automatic t_multi_match;
    sw_put(1'b0, 4'd5, 1'b0, mk_match(19'h00C05, 1'b1, 1'b0));
    sw_put(1'b0, 4'd5, 1'b1, mk_xlate(19'h00AAA, ALL_RW));
    sw_put(1'b1, 4'd5, 1'b0, mk_match(19'h00C05, 1'b1, 1'b0));
    sw_put(1'b1, 4'd5, 1'b1, mk_xlate(19'h00BBB, ALL_RW));
    look(va(19'h00C05, 13'h0010), 1'b0, 1'b0);
    chk("R8", "highest way wins", rsp_paddr, {19'h00BBB, 13'h0010});
  endtask

  task automatic t_perm;
    // user read yes, user write no, sup read no, sup write yes
    sw_put(1'b0, 4'd9, 1'b0, mk_match(19'h00109, 1'b1, 1'b0));
    sw_put(1'b0, 4'd9, 1'b1, mk_xlate(19'h00321, 6'b100100));
    look(va(19'h00109, 13'h0005), 1'b0, 1'b0);
    chk("R5", "user read fault", 32'(fault_req), 32'd0);
    chk("R3", "user read paddr", rsp_paddr, {19'h00321, 13'h0005});
    look(va(19'h00109, 13'h0006), 1'b1, 1'b0);
    chk("R5", "user write fault", 32'(fault_req), 32'd1);
    chk("R5", "user write hit", 32'(rsp_hit), 32'd1);
    chk("R5", "fault address", fault_vaddr, va(19'h00109, 13'h0006));
    look(va(19'h00109, 13'h0007), 1'b0, 1'b1);
    chk("R5", "sup read fault", 32'(fault_req), 32'd1);
    look(va(19'h00109, 13'h0008), 1'b1, 1'b1);
    chk("R5", "sup write fault", 32'(fault_req), 32'd0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11", "idle valid", 32'(rsp_valid), 32'd0);
    chk("R11", "idle miss", 32'(miss_req), 32'd0);
  endtask

  initial begin
    rst = 1'b1; xlate_en = 1'b1; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_super = 1'b0; sw_wr_en = 1'b0; sw_way = '0;
    sw_set = '0; sw_sel_xlate = 1'b0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_basic_hit();
    t_usage_victim();
    t_sw_priority();
    t_bypass();
    t_vpn_compare();
    t_multi_match();
    t_perm();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule